// File: doc/BRIEF.md
# Newton Reciprocal Fixed-Point Divider

This block divides one integer operand by another. It does not use a digit-by-digit recurrence. It first finds the reciprocal of the divisor with a seeded Newton iteration and then multiplies the dividend by that reciprocal. The divisor magnitude is normalised to a mantissa in [1/2, 1) times a power of two. The reciprocal of the mantissa starts from the seed 1.0, which is the power-of-two estimate 2^-p of the full divisor after rescaling. It is then refined a fixed, parameterised number of times with y' = y * (2 - y * d). Every product goes through one shared multiplier, which may be pipelined. After the dividend multiply, one remainder multiply and a short correction loop turn the estimate into the exact truncated quotient.

A caller presents both operands with a one-cycle `start` pulse while the block is idle. `busy` then stays high until the result is ready. The result is announced by a one-cycle `done` pulse, and `quotient` and `div_err` keep their values until the next completion. Operands are two's complement when `SIGNED` is 1, which is the default. A zero divisor does not start the iteration. It completes on the next cycle with the error flag set.

Top module: `nr_recip_div`

## Requirements
- R1: For every nonzero divisor, the quotient magnitude equals floor(|dividend| / |divisor|) exactly. This includes divisors of 1 and powers of two, and dividends smaller than the divisor.
- R2: With signed operands in two's complement, the quotient is negated when exactly one operand is negative. Division therefore truncates toward zero.
- R3: A start with divisor 0 produces, on the next cycle, done=1, div_err=1 and quotient=0, and busy is never raised for it.
- R4: done is high for one cycle only, unless a new start with divisor 0 arrives in that same cycle. quotient and div_err change only in a cycle where done is high.
- R5: After an accepted start with a nonzero divisor, busy is high from the next cycle up to the cycle before done. busy is low in the done cycle.
- R6: A start pulse while busy is high is ignored. The running divide completes with the operands it was started with.
- R7: The most negative value divided by -1 yields the most negative value, because the result wraps to W bits.
- R8: A completed divide with a nonzero divisor clears div_err.
- R9: done arrives no more than 2*(ITERS+2)*(MUL_STAGES+1)+8 cycles after the clock edge that accepts start.
- R10: After reset, busy, done and div_err are low and quotient is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a divide; accepted only while busy is low |
| dividend | input | W | Numerator operand |
| divisor | input | W | Denominator operand |
| busy | output | 1 | Divide in progress |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | Last completed divide had a zero divisor |
| quotient | output | W | Truncated quotient of the last completed divide |

## Verification
The hardest case to reach is the correction loop running in the upward direction. In that case the truncated reciprocal leaves the product estimate one below the true quotient, and the remainder must be walked back into range. This happens mainly when the dividend is large and the divisor is far from a power of two. The random stimulus therefore pairs full-range dividends with divisors drawn at many magnitudes, using a random right shift of a random word. Directed cases cover the edges that random draws almost never hit: powers of two, ±1, the most negative value, zero operands, and a start pulse that arrives mid-operation.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;

   // Sequencer states of the divider
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,   // waiting for start
      ST_NORM = 3'd1,   // left-align divisor, seed reciprocal
      ST_TX   = 3'd2,   // multiply: mantissa * reciprocal
      ST_YU   = 3'd3,   // multiply: reciprocal * (2 - t)
      ST_QA   = 3'd4,   // multiply: dividend magnitude * reciprocal
      ST_QM   = 3'd5,   // multiply: estimate * divisor magnitude
      ST_FIX  = 3'd6    // step the estimate until remainder is in range
   } nrdiv_state_e;

endpackage

// File: rtl/nrdiv_sign.sv
module nrdiv_sign #(
   parameter int W      = 16,
   parameter bit SIGNED = 1'b1
) (
   input  logic [W-1:0] val,
   output logic [W-1:0] mag,
   output logic         neg
);

   generate
      if (SIGNED) begin : g_twos
         // Magnitude of the most negative value is 2^(W-1), still W bits unsigned
         assign neg = val[W-1];
         assign mag = val[W-1] ? (~val + W'(1)) : val;
      end else begin : g_plain
         assign neg = 1'b0;
         assign mag = val;
      end
   endgenerate

endmodule

// File: rtl/nrdiv_lead_one.sv
module nrdiv_lead_one #(
   parameter int W  = 16,
   localparam int LW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  val,
   output logic [LW-1:0] pos
);

   // Each stage keeps the highest set bit seen so far
   logic [LW-1:0] chain [W+1];

   assign chain[0] = '0;

   generate
      for (genvar i = 0; i < W; i++) begin : g_scan
         assign chain[i+1] = val[i] ? LW'(i) : chain[i];
      end
   endgenerate

   assign pos = chain[W];

endmodule

// File: rtl/nrdiv_mul.sv
module nrdiv_mul #(
   parameter int AW     = 22,
   parameter int STAGES = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   op_a,
   input  logic [AW-1:0]   op_b,
   output logic [2*AW-1:0] prod
);

   logic [2*AW-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[0] <= '0;
      else        pipe[0] <= op_a * op_b;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= '0;
            else        pipe[s] <= pipe[s-1];
         end
      end
   endgenerate

   assign prod = pipe[STAGES-1];

endmodule

// File: rtl/nr_recip_div.sv
module nr_recip_div
   import nrdiv_pkg::*;
#(
   parameter int W          = 16,
   parameter int GUARD      = 4,
   parameter int ITERS      = 5,
   parameter int MUL_STAGES = 1,
   parameter bit SIGNED     = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic         busy,
   output logic         done,
   output logic         div_err,
   output logic [W-1:0] quotient
);

   localparam int FB = W + GUARD;            // fraction bits of reciprocal
   localparam int MW = FB + 2;               // multiplier operand width
   localparam int PW = 2 * MW;               // product width
   localparam int LW = $clog2(W);            // leading-one index width
   localparam int SW = $clog2(W + 1);        // exponent width (1..W)
   localparam int QW = W + 1;                // estimate width
   localparam int RW = W + 3;                // signed remainder width
   localparam int IW = $clog2(ITERS + 1);
   localparam int CW = $clog2(MUL_STAGES + 1);
   localparam logic [MW-1:0] Y_ONE = MW'(1) << FB;
   localparam logic [MW-1:0] Y_TWO = MW'(1) << (FB + 1);

   // Elaboration-time parameter checks
   generate
      if (W < 4)                           begin : g_bad_w     $error("W must be at least 4");            end
      if (GUARD < 2)                       begin : g_bad_guard $error("GUARD must be at least 2");        end
      if (ITERS < 1)                       begin : g_bad_iters $error("ITERS must be at least 1");        end
      if (MUL_STAGES < 1 || MUL_STAGES > 4) begin : g_bad_mul  $error("MUL_STAGES must be in 1..4");      end
   endgenerate

   nrdiv_state_e          state;
   logic [W-1:0]          a_mag, m_mag;
   logic                  q_neg;
   logic [MW-1:0]         dn, y, u;
   logic [SW-1:0]         sh_p;
   logic [QW-1:0]         qv;
   logic signed [RW-1:0]  rem;
   logic [IW-1:0]         iter;
   logic [CW-1:0]         cnt;
   logic                  busy_q, done_q, err_q;
   logic [W-1:0]          quot_q;

   // Operand preparation
   logic [W-1:0] dvd_mag, dvs_mag;
   logic         dvd_neg, dvs_neg;

   nrdiv_sign #(.W(W), .SIGNED(SIGNED)) u_sgn_a (.val(dividend), .mag(dvd_mag), .neg(dvd_neg));
   nrdiv_sign #(.W(W), .SIGNED(SIGNED)) u_sgn_b (.val(divisor),  .mag(dvs_mag), .neg(dvs_neg));

   // Normalisation of the stored divisor magnitude
   logic [LW-1:0] lz_pos;
   logic [MW-1:0] dn_next;
   logic [SW-1:0] p_next;

   nrdiv_lead_one #(.W(W)) u_lead (.val(m_mag), .pos(lz_pos));

   always_comb begin
      dn_next = MW'(m_mag) << (FB - 1 - int'(lz_pos));
      p_next  = SW'(lz_pos) + SW'(1);
   end

   // Shared multiplier and its operand select
   logic [MW-1:0] mul_a, mul_b;
   logic [PW-1:0] prod;

   always_comb begin
      mul_a = '0;
      mul_b = '0;
      unique case (state)
         ST_TX: begin mul_a = dn;          mul_b = y;          end
         ST_YU: begin mul_a = y;           mul_b = u;          end
         ST_QA: begin mul_a = MW'(a_mag);  mul_b = y;          end
         ST_QM: begin mul_a = MW'(qv);     mul_b = MW'(m_mag); end
         default: ;
      endcase
   end

   nrdiv_mul #(.AW(MW), .STAGES(MUL_STAGES)) u_mul (
      .clk   (clk),
      .rst_n (rst_n),
      .op_a  (mul_a),
      .op_b  (mul_b),
      .prod  (prod)
   );

   // Views of the product used by each step
   logic [MW-1:0]        prod_fx;
   logic [QW-1:0]        q_est;
   logic signed [RW-1:0] rem_next, m_ext;
   logic                 mul_ok;
   logic [W-1:0]         q_low;

   always_comb begin
      prod_fx  = MW'(prod >> FB);
      q_est    = QW'(prod >> (FB + int'(sh_p)));
      rem_next = $signed({3'b000, a_mag}) - $signed(prod[RW-1:0]);
      m_ext    = $signed({3'b000, m_mag});
      mul_ok   = (cnt == CW'(MUL_STAGES));
      q_low    = qv[W-1:0];
   end

   // Sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         a_mag  <= '0;
         m_mag  <= '0;
         q_neg  <= 1'b0;
         dn     <= '0;
         y      <= '0;
         u      <= '0;
         sh_p   <= '0;
         qv     <= '0;
         rem    <= '0;
         iter   <= '0;
         cnt    <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         quot_q <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  if (divisor == '0) begin
                     done_q <= 1'b1;
                     err_q  <= 1'b1;
                     quot_q <= '0;
                  end else begin
                     a_mag  <= dvd_mag;
                     m_mag  <= dvs_mag;
                     q_neg  <= dvd_neg ^ dvs_neg;
                     busy_q <= 1'b1;
                     state  <= ST_NORM;
                  end
               end
            end
            ST_NORM: begin
               dn    <= dn_next;
               sh_p  <= p_next;
               y     <= Y_ONE;
               iter  <= '0;
               cnt   <= '0;
               state <= ST_TX;
            end
            ST_TX: begin
               if (!mul_ok) cnt <= cnt + CW'(1);
               else begin
                  cnt   <= '0;
                  u     <= Y_TWO - prod_fx;
                  state <= ST_YU;
               end
            end
            ST_YU: begin
               if (!mul_ok) cnt <= cnt + CW'(1);
               else begin
                  cnt  <= '0;
                  y    <= prod_fx;
                  iter <= iter + IW'(1);
                  if (iter == IW'(ITERS - 1)) state <= ST_QA;
                  else                        state <= ST_TX;
               end
            end
            ST_QA: begin
               if (!mul_ok) cnt <= cnt + CW'(1);
               else begin
                  cnt   <= '0;
                  qv    <= q_est;
                  state <= ST_QM;
               end
            end
            ST_QM: begin
               if (!mul_ok) cnt <= cnt + CW'(1);
               else begin
                  cnt   <= '0;
                  rem   <= rem_next;
                  state <= ST_FIX;
               end
            end
            ST_FIX: begin
               if (rem < 0) begin
                  rem <= rem + m_ext;
                  qv  <= qv - QW'(1);
               end else if (rem >= m_ext) begin
                  rem <= rem - m_ext;
                  qv  <= qv + QW'(1);
               end else begin
                  quot_q <= q_neg ? (W'(0) - q_low) : q_low;
                  err_q  <= 1'b0;
                  done_q <= 1'b1;
                  busy_q <= 1'b0;
                  state  <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy     = busy_q;
   assign done     = done_q;
   assign div_err  = err_q;
   assign quotient = quot_q;

endmodule

// File: rtl/nrdiv_chk.sv
module nrdiv_chk #(
   parameter int W          = 16,
   parameter int ITERS      = 5,
   parameter int MUL_STAGES = 1
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic [W-1:0] divisor,
   input logic         busy,
   input logic         done,
   input logic         div_err,
   input logic [W-1:0] quotient
);

   localparam int LAT_MAX = 2 * (ITERS + 2) * (MUL_STAGES + 1) + 8;

   logic        zdiv_q;
   logic [15:0] lat_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zdiv_q  <= 1'b0;
         lat_cnt <= '0;
      end else begin
         if (start && !busy) zdiv_q <= (divisor == '0);
         if (!busy)          lat_cnt <= '0;
         else if (lat_cnt != 16'hFFFF) lat_cnt <= lat_cnt + 16'd1;
      end
   end

   p_zero_div_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && divisor == '0 |=> done && div_err && quotient == '0 && !busy);

   p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> !done);

   p_quot_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(quotient));

   p_err_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(div_err));

   p_busy_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && divisor != '0 |=> busy && !done);

   p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_err_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> div_err == zdiv_q);

   p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> lat_cnt < 16'(LAT_MAX));

endmodule

bind nr_recip_div nrdiv_chk #(.W(W), .ITERS(ITERS), .MUL_STAGES(MUL_STAGES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .divisor  (divisor),
   .busy     (busy),
   .done     (done),
   .div_err  (div_err),
   .quotient (quotient)
);

// File: tb/nr_recip_div_tb_top.sv
module nr_recip_div_tb_top;

   localparam int  W          = 16;
   localparam int  ITERS      = 5;
   localparam int  MUL_STAGES = 1;
   localparam time CLK_PERIOD = 10ns;
   localparam int  LAT_MAX    = 2 * (ITERS + 2) * (MUL_STAGES + 1) + 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] dividend = '0;
   logic [W-1:0] divisor = '0;
   logic         busy, done, div_err;
   logic [W-1:0] quotient;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nr_recip_div #(.W(W), .ITERS(ITERS), .MUL_STAGES(MUL_STAGES), .SIGNED(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
      .busy(busy), .done(done), .div_err(div_err), .quotient(quotient)
   );

   function automatic logic [W-1:0] ref_quot(logic [W-1:0] a, logic [W-1:0] b);
      longint ia, ib, q;
      ia = longint'($signed(a));
      ib = longint'($signed(b));
      if (ib == 0) return '0;
      q = ia / ib;
      return q[W-1:0];
   endfunction

   task automatic check(bit ok, string req, longint act, longint exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
         $finish;
      end
   endtask

   // One divide; optionally a second start pulse in mid-flight (must be ignored)
   task automatic run_op(logic [W-1:0] a, logic [W-1:0] b, bit inject);
      logic [W-1:0] exp_q;
      logic [W-1:0] held;
      int cyc;
      exp_q = ref_quot(a, b);
      @(negedge clk);
      start = 1'b1; dividend = a; divisor = b;
      @(negedge clk);
      start = 1'b0; dividend = ~a; divisor = '0;
      cyc = 1;
      if (b == '0) begin
         check(done === 1'b1 && div_err === 1'b1 && quotient === '0 && busy === 1'b0,
               "R3", {done, div_err, busy}, 3'b110);
      end else begin
         check(busy === 1'b1 && done === 1'b0, "R5", {busy, done}, 2'b10);
         while (done !== 1'b1 && cyc <= LAT_MAX + 4) begin
            if (inject && cyc == 2) begin
               start = 1'b1; dividend = a + W'(7); divisor = b ^ W'(3);
            end else begin
               start = 1'b0;
            end
            @(negedge clk);
            cyc++;
            if (done !== 1'b1 && busy !== 1'b1) check(1'b0, "R5", busy, 1);
         end
         start = 1'b0;
         check(cyc <= LAT_MAX, "R9", cyc, LAT_MAX);
         check(quotient === exp_q, inject ? "R6" : "R1/R2", quotient, exp_q);
         check(div_err === 1'b0, "R8", div_err, 0);
         check(busy === 1'b0, "R5", busy, 0);
      end
      held = quotient;
      @(negedge clk);
      check(done === 1'b0 && quotient === held, "R4", {done, quotient}, {1'b0, held});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      report();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R10: reset values
      check(busy === 1'b0 && done === 1'b0 && div_err === 1'b0 && quotient === '0,
            "R10", {busy, done, div_err, quotient}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy === 1'b0 && done === 1'b0 && quotient === '0, "R10", {busy, done}, 0);

      // Directed corners
      run_op(16'd100,  16'd7,   1'b0);   // R1
      run_op(16'd0,    16'd0,   1'b0);   // R3
      run_op(16'd5000, 16'd1,   1'b0);   // R1 unit divisor, R8 clears err
      run_op(16'd3,    16'd9,   1'b0);   // R1 small dividend
      run_op(16'h7FFF, 16'h4000,1'b0);   // R1 power of two
      run_op(16'h7FFF, 16'd2,   1'b0);   // R1
      run_op(16'h8000, 16'hFFFF,1'b0);   // R7 wrap
      run_op(16'h8000, 16'd1,   1'b0);   // R2 most negative / 1
      run_op(-16'sd100, 16'd7,  1'b0);   // R2
      run_op(16'd100, -16'sd7,  1'b0);   // R2
      run_op(-16'sd100,-16'sd7, 1'b0);   // R2
      run_op(16'd1234, 16'h8000,1'b0);   // R1 most negative divisor
      run_op(16'h7FFF, 16'h7FFF,1'b0);   // R1
      run_op(16'd0,    16'd55,  1'b0);   // R1 zero dividend
      run_op(16'd31000,16'd3,   1'b1);   // R6 start while busy
      run_op(16'hABCD, 16'd0,   1'b0);   // R3 again
      run_op(16'd77,   16'd7,   1'b0);   // R8 err cleared

      // Random mix across divisor magnitudes
      for (int i = 0; i < 400; i++) begin
         logic [W-1:0] ra, rb;
         ra = W'($urandom);
         rb = W'($urandom >> ($urandom % 32));
         if (($urandom % 40) == 0) rb = '0;
         run_op(ra, rb, (i % 50) == 0);
      end
      report();
   end

endmodule